// File: doc/BRIEF.md
# Logic Cell Output Conditioner with Edge Flag

This block sits behind the combinational or state function of a configurable logic cell and turns its raw result into the cell's visible output. An inversion control can flip the raw result. While the cell is switched off, the output is held at 0. The result is presented as a status level. It also drives a pin, but only when both the cell enable and the pin enable are on.

A sticky interrupt flag watches the conditioned output for rising and falling transitions. Each direction has its own enable. The history of the output is kept in a register clocked by the system clock, so a cell that is off counts as having a 0 output. Switching the cell on while its output is 1, with rising detection armed, therefore counts as a rising edge. The flag is set no matter what the interrupt mask says; the mask only gates the request line. Software clears the flag with a one-cycle clear pulse. An edge that lands in the same cycle as the clear wins, so no event is lost.

All pins are plain level controls and status levels. No data stream passes through the block, so there is no handshake at its edge.

Top module: `lcell_out_cond`

## Requirements
- R1: While `cell_en` is 1, `out_status` equals `raw_in` XOR `out_invert` in the same cycle (combinational path).
- R2: While `cell_en` is 0, `out_status` is 0 whatever `raw_in` and `out_invert` are.
- R3: `pin_drive` is 1 exactly when `cell_en` and `pin_oe` are both 1. `pin_out` equals `out_status` when `pin_drive` is 1 and is 0 otherwise.
- R4: With `rise_irq_en` at 1 and the cell enabled, a cycle where `out_status` is 1 and its registered previous value is 0 sets `irq_flag` at the next rising clock edge.
- R5: With `fall_irq_en` at 1 and the cell enabled, a cycle where `out_status` is 0 and its registered previous value is 1 sets `irq_flag` at the next rising clock edge.
- R6: A transition whose direction enable is 0 does not set `irq_flag`.
- R7: `irq_flag` is never set by a cycle in which `cell_en` is 0. Turning the cell off while its output is 1, with `fall_irq_en` at 1, leaves the flag unchanged.
- R8: The previous-value register follows `out_status`, which is 0 while the cell is off. Enabling the cell while `raw_in` XOR `out_invert` is 1, with `rise_irq_en` at 1, therefore sets `irq_flag`.
- R9: `irq_flag` holds its value until a cycle with `flag_clr` at 1 and no qualifying edge, and then reads 0 after the next rising edge. A qualifying edge in the same cycle as `flag_clr` keeps the flag at 1.
- R10: `irq_req` equals `irq_flag` AND `irq_mask`. The flag is set by edges whatever the value of `irq_mask`.
- R11: An active-low reset clears `irq_flag` and the previous-value register. In the first enabled cycle after reset, an output of 1 with rising detection on sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_in | input | 1 | Raw result of the cell's logic function |
| cell_en | input | 1 | Cell enable; 0 forces the output to 0 |
| pin_oe | input | 1 | Request to drive the pin |
| out_invert | input | 1 | 1 inverts the raw result |
| rise_irq_en | input | 1 | Arms rising-edge detection |
| fall_irq_en | input | 1 | Arms falling-edge detection |
| irq_mask | input | 1 | 1 lets the flag reach `irq_req` |
| flag_clr | input | 1 | One-cycle clear pulse for the flag |
| out_status | output | 1 | Conditioned output level |
| pin_out | output | 1 | Value driven onto the pin (0 when not driven) |
| pin_drive | output | 1 | Pin drive enable |
| irq_flag | output | 1 | Sticky edge flag |
| irq_req | output | 1 | Masked interrupt request |

## Verification
`out_status`, `pin_out`, `pin_drive` and `irq_req` are combinational and follow the inputs within the same cycle. The bench drives its inputs on the falling clock edge and compares these outputs 1 ns later, before the next rising edge. `irq_flag` has one register on its path, so an edge or clear seen in a cycle shows up only after the following rising edge. The bench checks the flag 2 ns after that edge, against a model whose flag and previous-output state advance once per rising edge.

// File: rtl/lcell_pkg.sv
package lcell_pkg;

  // Qualified transition events produced by the edge detector
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_evt_t;

  localparam logic FLAG_RESET_VAL = 1'b0;
  localparam logic HIST_RESET_VAL = 1'b0;

  function automatic logic any_evt(edge_evt_t e);
    return e.rise | e.fall;
  endfunction

endpackage

// File: rtl/lcell_polarity_gate.sv
module lcell_polarity_gate (
  input  logic raw_in,
  input  logic invert,
  input  logic en,
  input  logic oe,
  output logic level_o,
  output logic pin_val_o,
  output logic pin_drv_o
);

  logic polarized;

  always_comb begin
    polarized = raw_in ^ invert;
    level_o   = en ? polarized : 1'b0;
    pin_drv_o = en & oe;
    pin_val_o = pin_drv_o ? level_o : 1'b0;
  end

endmodule

// File: rtl/lcell_edge_detect.sv
module lcell_edge_detect
  import lcell_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      level,
  input  logic      rise_en,
  input  logic      fall_en,
  output edge_evt_t evt_o
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= HIST_RESET_VAL;
    else        prev_q <= level;
  end

  always_comb begin
    evt_o.rise = en & rise_en &  level & ~prev_q;
    evt_o.fall = en & fall_en & ~level &  prev_q;
  end

  // R8
  hist_zero_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !prev_q);

  // R6
  rise_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_en && !fall_en) |-> !any_evt(evt_o));

endmodule

// File: rtl/lcell_irq_flag.sv
module lcell_irq_flag
  import lcell_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  edge_evt_t evt,
  input  logic      clr,
  input  logic      mask,
  output logic      flag_o,
  output logic      req_o
);

  logic flag_q;
  logic flag_d;

  always_comb begin
    if (any_evt(evt)) flag_d = 1'b1;
    else if (clr)     flag_d = 1'b0;
    else              flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= FLAG_RESET_VAL;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
  assign req_o  = flag_q & mask;

  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);

  // R9
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !any_evt(evt)) |=> !flag_q);

  // R4
  event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_evt(evt) |=> flag_q);

endmodule

// File: rtl/lcell_out_cond.sv
module lcell_out_cond
  import lcell_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  input  logic cell_en,
  input  logic pin_oe,
  input  logic out_invert,
  input  logic rise_irq_en,
  input  logic fall_irq_en,
  input  logic irq_mask,
  input  logic flag_clr,
  output logic out_status,
  output logic pin_out,
  output logic pin_drive,
  output logic irq_flag,
  output logic irq_req
);

  logic      level;
  edge_evt_t evt;

  lcell_polarity_gate u_pol (
    .raw_in    (raw_in),
    .invert    (out_invert),
    .en        (cell_en),
    .oe        (pin_oe),
    .level_o   (level),
    .pin_val_o (pin_out),
    .pin_drv_o (pin_drive)
  );

  lcell_edge_detect u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cell_en),
    .level   (level),
    .rise_en (rise_irq_en),
    .fall_en (fall_irq_en),
    .evt_o   (evt)
  );

  lcell_irq_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (evt),
    .clr    (flag_clr),
    .mask   (irq_mask),
    .flag_o (irq_flag),
    .req_o  (irq_req)
  );

  assign out_status = level;

  // R7
  flag_rise_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(cell_en));

  // R5
  fall_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_en && fall_irq_en && $fell(out_status)) |=> irq_flag);

  // R3
  pin_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_drive |-> (pin_out == out_status));

endmodule

// File: tb/sim_lcell_out_cond.sv
module sim_lcell_out_cond;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic raw_in = 0, cell_en = 0, pin_oe = 0, out_invert = 0;
  logic rise_irq_en = 0, fall_irq_en = 0, irq_mask = 0, flag_clr = 0;
  logic out_status, pin_out, pin_drive, irq_flag, irq_req;

  int n_chk = 0;
  int n_bad = 0;
  logic m_prev = 1'b0;
  logic m_flag = 1'b0;

  always #10 clk = ~clk;

  lcell_out_cond u0 (
    .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .cell_en(cell_en),
    .pin_oe(pin_oe), .out_invert(out_invert), .rise_irq_en(rise_irq_en),
    .fall_irq_en(fall_irq_en), .irq_mask(irq_mask), .flag_clr(flag_clr),
    .out_status(out_status), .pin_out(pin_out), .pin_drive(pin_drive),
    .irq_flag(irq_flag), .irq_req(irq_req)
  );

  function automatic logic exp_level(logic en, logic raw, logic inv);
    return en & (raw ^ inv);
  endfunction

  task automatic check(input logic act, input logic exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary_and_end();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // One full cycle: drive at falling edge, check combinational outputs, then flag
  task automatic cycle(input logic en, input logic raw, input logic inv, input logic oe,
                       input logic re, input logic fe, input logic msk, input logic clr);
    logic f, r, fl, nflag;
    string tag;
    @(negedge clk);
    cell_en = en; raw_in = raw; out_invert = inv; pin_oe = oe;
    rise_irq_en = re; fall_irq_en = fe; irq_mask = msk; flag_clr = clr;
    #1;
    f = exp_level(en, raw, inv);
    check(out_status, f, en ? "R1" : "R2", "out_status");
    check(pin_drive, en & oe, "R3", "pin_drive");
    check(pin_out, (en & oe) ? f : 1'b0, "R3", "pin_out");
    check(irq_req, m_flag & msk, "R10", "irq_req");
    r  = en & re & f & ~m_prev;
    fl = en & fe & ~f & m_prev;
    nflag = (r | fl) ? 1'b1 : (clr ? 1'b0 : m_flag);
    if (r)       tag = (m_prev == 1'b0 && !m_flag) ? "R4" : "R4";
    else if (fl) tag = "R5";
    else if (clr) tag = "R9";
    else if (!en) tag = "R7";
    else          tag = "R6";
    @(posedge clk);
    #2;
    m_flag = nflag;
    m_prev = f;
    check(irq_flag, m_flag, tag, "irq_flag");
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary_and_end();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R11: reset state
    check(irq_flag, 1'b0, "R11", "flag in reset");
    check(out_status, 1'b0, "R11", "status in reset");
    rst_n = 1'b1;
    // R11 / R8: first enabled cycle with output 1 and rising armed
    cycle(1, 1, 0, 1, 1, 0, 0, 0);
    check(irq_flag, 1'b1, "R8", "enable-at-one raises flag");
    cycle(1, 1, 0, 1, 1, 0, 0, 0);
    check(irq_flag, 1'b1, "R9", "flag sticky");
    // R9: falling edge coincides with clear, edge wins
    cycle(1, 0, 0, 0, 0, 1, 0, 1);
    check(irq_flag, 1'b1, "R9", "edge beats clear");
    cycle(1, 0, 0, 0, 0, 1, 0, 1);
    check(irq_flag, 1'b0, "R9", "clear alone");
    // R6: rising edge with only falling armed
    cycle(1, 0, 1, 0, 0, 1, 0, 0);
    check(irq_flag, 1'b0, "R6", "unarmed rise ignored");
    // R7: switch off while high, falling armed
    cycle(0, 1, 0, 0, 0, 1, 0, 0);
    check(irq_flag, 1'b0, "R7", "disable gives no flag");
    // R8 via inversion: raw 0, invert 1
    cycle(1, 0, 1, 1, 1, 0, 0, 0);
    check(irq_flag, 1'b1, "R8", "enable with inverted one");
    // R10: mask gates request only
    cycle(1, 0, 1, 1, 0, 0, 1, 0);
    check(irq_req, 1'b1, "R10", "unmasked request");
    cycle(1, 0, 1, 1, 0, 0, 0, 1);
    // R5: falling edge with mask off still sets flag
    cycle(1, 1, 0, 1, 0, 1, 0, 0);
    cycle(1, 0, 0, 1, 0, 1, 0, 0);
    check(irq_flag, 1'b1, "R5", "fall sets flag masked");
    // Random phase
    for (int i = 0; i < 4000; i++) begin
      cycle(($urandom % 8) != 0, $urandom % 2, ($urandom % 6) == 0,
            $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
            ($urandom % 5) == 0);
    end
    summary_and_end();
  end

endmodule